// File: doc/BRIEF.md
# Integer ALU with Embedded HI/LO Pair

This block is a 32-bit integer arithmetic and logic unit for a small RISC-style core. Its operation is chosen by a 6-bit function code: the same value the R-type instruction word carries in its function field. The datapath is combinational. The result, the overflow trap and the illegal-code flag all settle in the same cycle that the operands are presented.

The block also holds the two special multiply/divide result registers, HI and LO. The move-to operations write them and the move-from operations read them. The write happens on a rising clock edge, and only while the execute strobe is high. Both registers are brought out as ports so that a core or a bench can observe them. Multiply and divide, the general register file, decode and pipelining belong to other blocks.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `alu_hilo_core`

## Requirements
- R1: Function codes 0 (shift left logical), 2 (shift right logical) and 3 (shift right arithmetic) shift `src_b` by `shamt`. The result is on `result`.
- R2: Function codes 4, 6 and 7 are the variable forms of left logical, right logical and right arithmetic shift. They shift `src_b` by `src_a[4:0]` and ignore the upper bits of `src_a`. The arithmetic form refills from bit 31.
- R3: Code 32 (add) and code 34 (subtract) raise `ovf_trap` on signed two's-complement overflow. While the trap is high, `result` is zero. Without overflow they return the sum or difference and the trap stays low.
- R4: Code 33 (add unsigned) and code 35 (subtract unsigned) wrap modulo 2^32 and never raise `ovf_trap`. For example, 24 minus 66 gives 0xFFFFFFD6.
- R5: The bitwise codes are 36 (AND), 37 (OR), 38 (XOR) and 39 (NOR). Applied to 0xA81 and 0x603, they give 0x201, 0xE83, 0xC82 and 0xFFFFF17C.
- R6: Code 42 compares `src_a < src_b` as signed values and code 43 compares them as unsigned values. The result is 1 or 0, zero-extended to 32 bits.
- R7: Code 16 drives HI onto `result` and code 18 drives LO onto `result`. Neither changes HI or LO.
- R8: Code 17 loads `src_a` into HI and code 19 loads `src_a` into LO. The load happens on the rising edge where `exec_vld` is high. Both codes return a zero result and leave the other register of the pair unchanged.
- R9: HI and LO keep their values across any edge where `exec_vld` is low. They also keep their values under every code other than 17 and 19, and that includes a trapping add or subtract.
- R10: Any function code not listed above produces a zero result, raises `illegal_op` and changes no state.
- R11: While `rst_n` is low, HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_vld | input | 1 | Execute strobe; enables the HI/LO write |
| op_code | input | 6 | Function code selecting the operation |
| src_a | input | 32 | First operand (rs) |
| src_b | input | 32 | Second operand (rt or immediate) |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on add or subtract |
| illegal_op | output | 1 | Unrecognised function code |
| hi_val | output | 32 | Current HI value |
| lo_val | output | 32 | Current LO value |

## Verification
The case that is hardest to reach from the ports is a move-to code presented while `exec_vld` is low. The result is zero whether the write happens or not, so its absence can only be seen in the cycles that follow. The scoreboard therefore first loads a distinctive value into HI. It then issues a move-to-HI with the strobe low, and after that reads HI back through code 16. At every step it also compares both observation ports against its own model of the pair. The same readback follows a trapping add that is issued with the strobe high, and also illegal codes.

// File: rtl/alu_hl_pkg.sv
`timescale 1ns/1ps
package alu_hl_pkg;
  localparam int FN_W = 6;

  // Shift group
  localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FN_W-1:0] FN_SRA  = 6'd3;
  localparam logic [FN_W-1:0] FN_SLLV = 6'd4;
  localparam logic [FN_W-1:0] FN_SRLV = 6'd6;
  localparam logic [FN_W-1:0] FN_SRAV = 6'd7;
  // HI/LO moves
  localparam logic [FN_W-1:0] FN_MFHI = 6'd16;
  localparam logic [FN_W-1:0] FN_MTHI = 6'd17;
  localparam logic [FN_W-1:0] FN_MFLO = 6'd18;
  localparam logic [FN_W-1:0] FN_MTLO = 6'd19;
  // Arithmetic and logic
  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU = 6'd43;
endpackage

// File: rtl/alu_rst_sync.sv
`timescale 1ns/1ps
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
module alu_shift_unit
  import alu_hl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [FN_W-1:0]    fn,
  input  logic [DATA_W-1:0]  amt_src,
  input  logic [DATA_W-1:0]  val,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  out,
  output logic               hit
);
  logic [SHAMT_W-1:0] amt;
  logic               var_form;

  // Bit 2 of the code selects the variable-amount form
  always_comb begin
    var_form = fn[2];
    amt      = var_form ? amt_src[SHAMT_W-1:0] : shamt;
  end

  always_comb begin
    hit = 1'b1;
    out = '0;
    case (fn)
      FN_SLL, FN_SLLV: out = val << amt;
      FN_SRL, FN_SRLV: out = val >> amt;
      FN_SRA, FN_SRAV: out = DATA_W'($signed(val) >>> amt);
      default:         hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit
  import alu_hl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [FN_W-1:0]   fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] out,
  output logic              ovf,
  output logic              hit
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;
  logic              ovf_add, ovf_sub, lt_s, lt_u;

  always_comb begin
    sum     = a + b;
    diff    = a - b;
    ovf_add = (a[MSB] == b[MSB]) && (sum[MSB]  != a[MSB]);
    ovf_sub = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    lt_s    = $signed(a) < $signed(b);
    lt_u    = a < b;
  end

  always_comb begin
    hit = 1'b1;
    ovf = 1'b0;
    out = '0;
    case (fn)
      FN_ADD:  begin out = sum;  ovf = ovf_add; end
      FN_ADDU: out = sum;
      FN_SUB:  begin out = diff; ovf = ovf_sub; end
      FN_SUBU: out = diff;
      FN_AND:  out = a & b;
      FN_OR:   out = a | b;
      FN_XOR:  out = a ^ b;
      FN_NOR:  out = ~(a | b);
      FN_SLT:  out = {{(DATA_W-1){1'b0}}, lt_s};
      FN_SLTU: out = {{(DATA_W-1){1'b0}}, lt_u};
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_hilo_regs.sv
`timescale 1ns/1ps
module alu_hilo_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);
  logic [DATA_W-1:0] hi_q, lo_q, hi_nxt, lo_nxt;

  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (we_hi) hi_nxt = din;
    if (we_lo) lo_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (we_hi) hi_q <= hi_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (we_lo) lo_q <= lo_nxt;
  end

  assign hi = hi_q;
  assign lo = lo_q;

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_hi |=> $stable(hi_q)); // R9
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lo |=> $stable(lo_q)); // R9
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |=> hi_q == $past(din)); // R8
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> lo_q == $past(din)); // R8
endmodule

// File: rtl/alu_hilo_core.sv
`timescale 1ns/1ps
module alu_hilo_core
  import alu_hl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_vld,
  input  logic [FN_W-1:0]    op_code,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               ovf_trap,
  output logic               illegal_op,
  output logic [DATA_W-1:0]  hi_val,
  output logic [DATA_W-1:0]  lo_val
);
  logic              rst_n_s;
  logic [DATA_W-1:0] sh_out, ar_out, hi_q, lo_q;
  logic              sh_hit, ar_hit, ar_ovf;
  logic              we_hi, we_lo;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  alu_shift_unit #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .fn(op_code), .amt_src(src_a), .val(src_b), .shamt(shamt),
    .out(sh_out), .hit(sh_hit)
  );

  alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
    .fn(op_code), .a(src_a), .b(src_b),
    .out(ar_out), .ovf(ar_ovf), .hit(ar_hit)
  );

  always_comb begin
    we_hi = exec_vld && (op_code == FN_MTHI);
    we_lo = exec_vld && (op_code == FN_MTLO);
  end

  alu_hilo_regs #(.DATA_W(DATA_W)) u_hilo (
    .clk(clk), .rst_n(rst_n_s), .we_hi(we_hi), .we_lo(we_lo),
    .din(src_a), .hi(hi_q), .lo(lo_q)
  );

  always_comb begin
    result     = '0;
    illegal_op = 1'b0;
    ovf_trap   = 1'b0;
    if (sh_hit) begin
      result = sh_out;
    end else if (ar_hit) begin
      ovf_trap = ar_ovf;
      result   = ar_ovf ? '0 : ar_out;
    end else begin
      case (op_code)
        FN_MFHI:          result = hi_q;
        FN_MFLO:          result = lo_q;
        FN_MTHI, FN_MTLO: result = '0;
        default:          illegal_op = 1'b1;
      endcase
    end
  end

  assign hi_val = hi_q;
  assign lo_val = lo_q;

  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovf_trap |-> result == '0); // R3
  AST_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_code == FN_ADDU || op_code == FN_SUBU) |-> !ovf_trap); // R4
  AST_SET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_code == FN_SLT || op_code == FN_SLTU) |-> $countones(result) <= 1 && !result[DATA_W-1:1]); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_op |-> result == '0 && !ovf_trap); // R10
  AST_TRAP_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovf_trap |=> $stable(hi_q) && $stable(lo_q)); // R9
  AST_MOVE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (we_hi || we_lo) |-> result == '0); // R8
endmodule

// File: tb/alu_hilo_core_test.sv
`timescale 1ns/1ps
module alu_hilo_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_vld;
  logic [5:0]  op_code;
  logic [31:0] src_a, src_b;
  logic [4:0]  shamt;
  logic [31:0] result, hi_val, lo_val;
  logic        ovf_trap, illegal_op;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  typedef struct packed {
    logic [31:0] res;
    logic        trap;
    logic        ill;
    logic [31:0] hi;
    logic [31:0] lo;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  alu_hilo_core uut (
    .clk(clk), .rst_n(rst_n), .exec_vld(exec_vld), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .shamt(shamt), .result(result),
    .ovf_trap(ovf_trap), .illegal_op(illegal_op), .hi_val(hi_val), .lo_val(lo_val)
  );

  task automatic drive(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic vld, input logic [31:0] e_res,
                       input logic e_trap, input logic e_ill, input string tag);
    exp_t e;
    @(negedge clk);
    op_code = op; src_a = a; src_b = b; shamt = sh; exec_vld = vld;
    e.res = e_res; e.trap = e_trap; e.ill = e_ill; e.hi = m_hi; e.lo = m_lo;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (vld && op == 6'd17) m_hi = a;
    if (vld && op == 6'd19) m_lo = a;
  endtask

  // Monitor: compares settled outputs shortly after each negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (result !== e.res || ovf_trap !== e.trap || illegal_op !== e.ill ||
            hi_val !== e.hi || lo_val !== e.lo) begin
          errors++;
          $display("FAIL %s: got res=%h trap=%b ill=%b hi=%h lo=%h, expected res=%h trap=%b ill=%b hi=%h lo=%h",
                   t, result, ovf_trap, illegal_op, hi_val, lo_val,
                   e.res, e.trap, e.ill, e.hi, e.lo);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_vld = 1'b0; op_code = 6'd16;
    src_a = '0; src_b = '0; shamt = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (hi_val !== 32'h0 || lo_val !== 32'h0) begin
      errors++;
      $display("FAIL R11: got hi=%h lo=%h, expected 0 0", hi_val, lo_val);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drive(6'd16, 0, 0, 0, 1, 32'h0, 0, 0, "R11 hi after reset");
    drive(6'd18, 0, 0, 0, 1, 32'h0, 0, 0, "R11 lo after reset");
    // R1 constant shifts
    drive(6'd0, 0, 32'h1,        5'd4,  1, 32'h10,        0, 0, "R1 sll");
    drive(6'd2, 0, 32'h8000_0000, 5'd31, 1, 32'h1,        0, 0, "R1 srl");
    drive(6'd3, 0, 32'h8000_0000, 5'd4,  1, 32'hF800_0000, 0, 0, "R1 sra");
    // R2 variable shifts: only src_a[4:0]
    drive(6'd4, 32'hFFFF_FFE3, 32'h1,  5'd9, 1, 32'h8,  0, 0, "R2 sllv");
    drive(6'd6, 32'h24,        32'hF0, 5'd0, 1, 32'hF,  0, 0, "R2 srlv");
    drive(6'd7, 32'h8,   32'h8000_0010, 5'd0, 1, 32'hFF80_0000, 0, 0, "R2 srav");
    // R3 trapping add/sub
    drive(6'd32, 24, 66, 0, 1, 32'd90, 0, 0, "R3 add");
    drive(6'd34, 66, 24, 0, 1, 32'd42, 0, 0, "R3 sub");
    drive(6'd32, 32'h7FFF_FFFF, 32'h1, 0, 1, 32'h0, 1, 0, "R3 add overflow");
    drive(6'd34, 32'h8000_0000, 32'h1, 0, 1, 32'h0, 1, 0, "R3 sub overflow");
    // R4 wrapping
    drive(6'd33, 32'hFFFF_FFFF, 32'h2, 0, 1, 32'h1,        0, 0, "R4 addu");
    drive(6'd35, 24, 66,               0, 1, 32'hFFFF_FFD6, 0, 0, "R4 subu");
    drive(6'd33, 32'h7FFF_FFFF, 32'h1, 0, 1, 32'h8000_0000, 0, 0, "R4 addu no trap");
    // R5 logic
    drive(6'd36, 32'hA81, 32'h603, 0, 1, 32'h201,       0, 0, "R5 and");
    drive(6'd37, 32'hA81, 32'h603, 0, 1, 32'hE83,       0, 0, "R5 or");
    drive(6'd38, 32'hA81, 32'h603, 0, 1, 32'hC82,       0, 0, "R5 xor");
    drive(6'd39, 32'hA81, 32'h603, 0, 1, 32'hFFFF_F17C, 0, 0, "R5 nor");
    // R6 comparisons
    drive(6'd42, 32'hFFFF_FFE1, 24, 0, 1, 32'h1, 0, 0, "R6 slt neg<pos");
    drive(6'd42, 24, 32'hFFFF_FFE1, 0, 1, 32'h0, 0, 0, "R6 slt pos>neg");
    drive(6'd43, 32'hFFFF_FFE1, 24, 0, 1, 32'h0, 0, 0, "R6 sltu big");
    drive(6'd43, 24, 32,            0, 1, 32'h1, 0, 0, "R6 sltu small");
    // R8 move-to, R7 move-from
    drive(6'd17, 43, 0, 0, 1, 32'h0,  0, 0, "R8 mthi");
    drive(6'd16, 0,  0, 0, 1, 32'd43, 0, 0, "R7 mfhi");
    drive(6'd18, 0,  0, 0, 1, 32'd0,  0, 0, "R7 mflo untouched");
    drive(6'd19, 23, 0, 0, 1, 32'h0,  0, 0, "R8 mtlo");
    drive(6'd18, 0,  0, 0, 1, 32'd23, 0, 0, "R7 mflo");
    drive(6'd16, 0,  0, 0, 1, 32'd43, 0, 0, "R7 mfhi repeat");
    // R9 no write without strobe, nor from other codes
    drive(6'd17, 32'h55, 0, 0, 0, 32'h0,  0, 0, "R9 mthi strobe low");
    drive(6'd16, 0,      0, 0, 1, 32'd43, 0, 0, "R9 hi kept");
    drive(6'd19, 32'h66, 0, 0, 0, 32'h0,  0, 0, "R9 mtlo strobe low");
    drive(6'd18, 0,      0, 0, 1, 32'd23, 0, 0, "R9 lo kept");
    drive(6'd32, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 32'h0, 1, 0, "R9 trap keeps pair");
    drive(6'd16, 0, 0, 0, 1, 32'd43, 0, 0, "R9 hi after trap");
    // R10 illegal codes
    drive(6'd1,  32'h99, 32'h1, 5'd3, 1, 32'h0, 0, 1, "R10 code 1");
    drive(6'd20, 32'h99, 32'h1, 0,    1, 32'h0, 0, 1, "R10 code 20");
    drive(6'd63, 32'h99, 32'h1, 0,    1, 32'h0, 0, 1, "R10 code 63");
    drive(6'd18, 0, 0, 0, 1, 32'd23, 0, 0, "R10 lo unchanged");

    @(negedge clk);
    exec_vld = 1'b0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule